// File: doc/BRIEF.md
# Power-Line Control Frame Decoder

This block turns the receive-data output of a power-line carrier modem into decoded home-control commands. The modem pulls its receive line low once per transmitted bit, in either the first or the second half-cycle of that bit's two-half-cycle slot. The block does not sample each half-cycle. It stamps every falling edge with a free-running microsecond counter and works out each bit from the spacing to the previous accepted edge, taking the value of the previous bit into account. The spacing rules allow a tolerance of one sixth of a half-cycle.

A frame opens with a start code of three carrier half-cycles followed by an empty one. After the start code come nine data bits: four carry a house pattern and five carry a key pattern. Both patterns are mapped back to numbers. Every finished or failed frame yields one result. The result is a one-cycle strobe with a flag byte, a house number and a key number. The zero-crossing phase input is used to check the start code. The local-transmit input marks frames that arrive while the local transmitter is busy.

Top module: `plc_rx_decoder`

## Requirements
- R1: After reset the result strobe is low and the flag, house and key outputs are all zero.
- R2: A well-formed frame produces one result with flags 0 (1 if local-transmit was high at its first edge). The first four decoded bits form a house pattern p, mapped by p -> {12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9}[p]. The last five form a key pattern q, mapped to 16+q[4:1] when q[0] is 1 and otherwise to the house mapping of q[4:1].
- R3: The second and third edges of a frame must each arrive one half-cycle (within one sixth of a half-cycle) after the previous accepted edge, with the zero-crossing phase input differing from the phase saved at the earlier edge. Otherwise an error result is emitted at once.
- R4: After the third start edge an empty half-cycle is assumed, so the previous bit counts as 1. Following a 1 bit, a gap of two half-cycles decodes as 1 and a gap of three decodes as 0.
- R5: Following a 0 bit, a gap of one half-cycle decodes as 1 and a gap of two decodes as 0.
- R6: A data-edge gap matching none of the allowed spacings emits an error result at that edge. In an error result, flag bit 1 is set and house and key are zero.
- R7: An edge arriving less than the minimum gap after the last accepted edge of an open frame is ignored and does not move the reference time.
- R8: If an open frame has seen two or more edges and no edge is accepted for longer than the silence limit, an error result is emitted and the decoder returns to idle.
- R9: A frame that has seen only its first edge is dropped without a result when the silence limit expires.
- R10: Flag bit 0 copies the local-transmit input at the frame's first edge, in both good and error results. Flag bits 7..2 are zero.
- R11: A wrap of the timestamp counter between edges does not change how a gap is classified.
- R12: The result strobe lasts exactly one cycle, and the decoder accepts a new start edge from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Modem receive data, idle high; a falling edge marks carrier |
| zc_in | input | 1 | Mains zero-crossing phase level |
| local_tx | input | 1 | High while the local transmitter is sending |
| res_valid | output | 1 | One-cycle result strobe |
| res_flags | output | 8 | Bit 0 local frame, bit 1 error |
| res_house | output | 8 | Decoded house number 0..15 (0 on error) |
| res_key | output | 8 | Decoded key number 0..31 (0 on error) |

## Verification
The bound checker watches, on every cycle, that the strobe never lasts two cycles, that error results carry zero house and key, that the unused flag bits stay clear and that the decoder is idle whenever it reports. Gap classification, start-code phase checks, glitch rejection, the silence timeout with one edge and with several, and counter wrap can only be shown by the bench's scenarios. These scenarios place edges at chosen half-cycle positions and compare the decoded numbers with values taken from a forward encoding table.

// File: rtl/plc_rx_decoder.sv
module plc_rx_decoder #(
  parameter int TICK_DIV   = 50,
  parameter int HALF_US    = 8333,
  parameter int MIN_GAP_US = 1500,
  parameter int SILENCE_US = 50000,
  parameter int TS_W       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       zc_in,
  input  logic       local_tx,
  output logic       res_valid,
  output logic [7:0] res_flags,
  output logic [7:0] res_house,
  output logic [7:0] res_key
);
  localparam int TOL   = HALF_US / 6;
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DIV_W-1:0] presc;
  logic [TS_W-1:0]  ts, last_ts, gap;
  logic             rx_q, fall, busy, phase, loc;
  logic [4:0]       rcount;
  logic [8:0]       bits, nbits;
  logic             last_bit, is_one, is_zero;

  function automatic logic near(input logic [TS_W-1:0] g, input int m);
    longint e;
    e = longint'(HALF_US) * m;
    return (longint'(g) > e - TOL) && (longint'(g) < e + TOL);
  endfunction

  function automatic logic [3:0] house_inv(input logic [3:0] p);
    case (p)
      4'd0:  return 4'd12;
      4'd1:  return 4'd4;
      4'd2:  return 4'd2;
      4'd3:  return 4'd10;
      4'd4:  return 4'd14;
      4'd5:  return 4'd6;
      4'd6:  return 4'd0;
      4'd7:  return 4'd8;
      4'd8:  return 4'd13;
      4'd9:  return 4'd5;
      4'd10: return 4'd3;
      4'd11: return 4'd11;
      4'd12: return 4'd15;
      4'd13: return 4'd7;
      4'd14: return 4'd1;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [4:0] key_inv(input logic [4:0] q);
    return q[0] ? {1'b1, q[4:1]} : {1'b0, house_inv(q[4:1])};
  endfunction

  assign fall     = rx_q & ~rx_in;
  assign gap      = ts - last_ts;
  assign last_bit = (rcount == 5'd4) ? 1'b1 : bits[0];
  assign is_one   = last_bit ? near(gap, 2) : near(gap, 1);
  assign is_zero  = last_bit ? near(gap, 3) : near(gap, 2);
  assign nbits    = {bits[7:0], is_one};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      ts    <= '0;
    end else if (presc == DIV_W'(TICK_DIV - 1)) begin
      presc <= '0;
      ts    <= ts + 1'b1;
    end else begin
      presc <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q      <= 1'b1;
      busy      <= 1'b0;
      phase     <= 1'b0;
      loc       <= 1'b0;
      rcount    <= '0;
      bits      <= '0;
      last_ts   <= '0;
      res_valid <= 1'b0;
      res_flags <= '0;
      res_house <= '0;
      res_key   <= '0;
    end else begin
      rx_q      <= rx_in;
      res_valid <= 1'b0;
      if (!busy) begin
        if (fall) begin
          busy    <= 1'b1;
          rcount  <= 5'd1;
          bits    <= '0;
          loc     <= local_tx;
          phase   <= zc_in;
          last_ts <= ts;
        end
      end else if (fall && gap >= TS_W'(MIN_GAP_US)) begin
        last_ts <= ts;
        if (rcount < 5'd3) begin
          if (near(gap, 1) && zc_in != phase) begin
            if (rcount == 5'd2) begin
              rcount <= 5'd4;
            end else begin
              rcount <= 5'd2;
              phase  <= zc_in;
            end
          end else begin
            busy      <= 1'b0;
            res_valid <= 1'b1;
            res_flags <= {6'b0, 1'b1, loc};
            res_house <= '0;
            res_key   <= '0;
          end
        end else if (!(is_one || is_zero)) begin
          busy      <= 1'b0;
          res_valid <= 1'b1;
          res_flags <= {6'b0, 1'b1, loc};
          res_house <= '0;
          res_key   <= '0;
        end else begin
          bits <= nbits;
          if (rcount == 5'd20) begin
            busy      <= 1'b0;
            res_valid <= 1'b1;
            res_flags <= {6'b0, 1'b0, loc};
            res_house <= {4'b0, house_inv(nbits[8:5])};
            res_key   <= {3'b0, key_inv(nbits[4:0])};
          end else begin
            rcount <= rcount + 5'd2;
          end
        end
      end else if (gap > TS_W'(SILENCE_US)) begin
        busy <= 1'b0;
        if (rcount >= 5'd2) begin
          res_valid <= 1'b1;
          res_flags <= {6'b0, 1'b1, loc};
          res_house <= '0;
          res_key   <= '0;
        end
      end
    end
  end
endmodule

module plc_rx_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [7:0] res_flags,
  input logic [7:0] res_house,
  input logic [7:0] res_key,
  input logic       busy
);
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R12
  AST_ERROR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flags[1]) |-> (res_house == 8'd0 && res_key == 8'd0)); // R6
  AST_FLAG_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_flags[7:2] == 6'd0)); // R10
  AST_IDLE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy); // R12
  AST_GOOD_RANGES: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_flags[1]) |-> (res_house < 8'd16 && res_key < 8'd32)); // R2
endmodule

bind plc_rx_decoder plc_rx_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_flags(res_flags),
  .res_house(res_house), .res_key(res_key), .busy(busy)
);

// File: tb/plc_rx_decoder_tb.sv
module plc_rx_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF    = 60;
  localparam int MIN_GAP = 11;
  localparam int SILENCE = 360;
  localparam int TSW     = 12;

  logic clk = 1'b0, rst_n = 1'b0, rx_in = 1'b1, zc_in = 1'b0, local_tx = 1'b0;
  logic       res_valid;
  logic [7:0] res_flags, res_house, res_key;

  int checks = 0, errors = 0, n_res = 0, cyc = 0;
  logic [7:0] c_flags, c_house, c_key;
  int seq_h [0:15];
  int seq_n = 0, flip_idx = -1, glitch_idx = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plc_rx_decoder #(.TICK_DIV(1), .HALF_US(HALF), .MIN_GAP_US(MIN_GAP),
                   .SILENCE_US(SILENCE), .TS_W(TSW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .zc_in(zc_in), .local_tx(local_tx),
    .res_valid(res_valid), .res_flags(res_flags), .res_house(res_house), .res_key(res_key));

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && res_valid) begin
    n_res++;
    c_flags = res_flags;
    c_house = res_house;
    c_key   = res_key;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] hfwd(input int h);
    logic [3:0] t [0:15] = '{4'd6, 4'd14, 4'd2, 4'd10, 4'd1, 4'd9, 4'd5, 4'd13,
                             4'd7, 4'd15, 4'd3, 4'd11, 4'd0, 4'd8, 4'd4, 4'd12};
    return t[h];
  endfunction

  function automatic logic [4:0] kfwd(input int k);
    return (k >= 16) ? {4'(k - 16), 1'b1} : {hfwd(k), 1'b0};
  endfunction

  task automatic build_frame(input logic [8:0] pat);
    seq_h[0] = 0; seq_h[1] = 1; seq_h[2] = 2;
    for (int k = 0; k < 9; k++) seq_h[3+k] = 4 + 2*k + (pat[8-k] ? 0 : 1);
    seq_n = 12;
  endtask

  task automatic edge_now(input logic z);
    zc_in = z;
    rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic play();
    for (int i = 0; i < seq_n; i++) begin
      if (i > 0) begin
        int g;
        g = (seq_h[i] - seq_h[i-1]) * HALF;
        if (i - 1 == glitch_idx) begin
          repeat (4) @(negedge clk);
          edge_now(1'b1);
          repeat (g - 6) @(negedge clk);
        end else begin
          repeat (g - 1) @(negedge clk);
        end
      end
      edge_now(logic'(seq_h[i] % 2) ^ (i == flip_idx));
    end
  endtask

  task automatic expect_good(input int h, input int k, input logic loc, input string req);
    chk(n_res == 1, {req, " result count"}, n_res, 1);
    chk(c_flags == {7'b0, loc}, {req, " flags"}, c_flags, {7'b0, loc});
    chk(c_house == 8'(h), {req, " house"}, c_house, h);
    chk(c_key == 8'(k), {req, " key"}, c_key, k);
  endtask

  task automatic expect_err(input logic loc, input string req);
    chk(n_res == 1, {req, " result count"}, n_res, 1);
    chk(c_flags == {6'b0, 1'b1, loc}, {req, " flags"}, c_flags, {6'b0, 1'b1, loc});
    chk(c_house == 8'd0 && c_key == 8'd0, {req, " zero house/key"}, {c_house, c_key}, 0);
  endtask

  task automatic run_frame(input int h, input int k, input logic loc, input string req);
    build_frame({hfwd(h), kfwd(k)});
    local_tx = loc;
    n_res = 0;
    play();
    local_tx = 1'b0;
    repeat (10) @(negedge clk);
    expect_good(h, k, loc, req);
    repeat (300) @(negedge clk);
    chk(n_res == 1, {req, " R12 no extra result"}, n_res, 1);
  endtask

  task automatic t_reset();
    chk(res_valid == 1'b0, "R1 strobe", res_valid, 0);
    chk(res_flags == 8'd0, "R1 flags", res_flags, 0);
    chk(res_house == 8'd0 && res_key == 8'd0, "R1 house/key", {res_house, res_key}, 0);
  endtask

  task automatic t_bad_start_gap();
    seq_h[0] = 0; seq_h[1] = 2; seq_n = 2;
    n_res = 0;
    play();
    repeat (10) @(negedge clk);
    expect_err(1'b0, "R3 start gap");
    repeat (500) @(negedge clk);
  endtask

  task automatic t_bad_start_phase();
    seq_h[0] = 0; seq_h[1] = 1; seq_h[2] = 2; seq_n = 3;
    flip_idx = 2;
    n_res = 0;
    play();
    flip_idx = -1;
    repeat (10) @(negedge clk);
    expect_err(1'b0, "R3 start phase");
    repeat (500) @(negedge clk);
  endtask

  task automatic t_bad_data_gap();
    seq_h[0] = 0; seq_h[1] = 1; seq_h[2] = 2; seq_h[3] = 6; seq_n = 4;
    local_tx = 1'b1;
    n_res = 0;
    play();
    local_tx = 1'b0;
    repeat (10) @(negedge clk);
    expect_err(1'b1, "R6 R10 data gap");
    repeat (500) @(negedge clk);
  endtask

  task automatic t_glitch();
    build_frame({hfwd(7), kfwd(22)});
    glitch_idx = 4;
    n_res = 0;
    play();
    glitch_idx = -1;
    repeat (10) @(negedge clk);
    expect_good(7, 22, 1'b0, "R7 glitch ignored");
    repeat (300) @(negedge clk);
  endtask

  task automatic t_timeout_multi();
    seq_h[0] = 0; seq_h[1] = 1; seq_h[2] = 2; seq_n = 3;
    local_tx = 1'b1;
    n_res = 0;
    play();
    local_tx = 1'b0;
    repeat (SILENCE - 30) @(negedge clk);
    chk(n_res == 0, "R8 no result before silence limit", n_res, 0);
    repeat (60) @(negedge clk);
    expect_err(1'b1, "R8 R10 timeout");
    repeat (200) @(negedge clk);
  endtask

  task automatic t_timeout_single();
    seq_h[0] = 0; seq_n = 1;
    n_res = 0;
    play();
    repeat (SILENCE + 100) @(negedge clk);
    chk(n_res == 0, "R9 single edge dropped", n_res, 0);
    run_frame(2, 5, 1'b0, "R9 R12 ready after drop");
  endtask

  task automatic t_wrap();
    while ((cyc % (1 << TSW)) != (1 << TSW) - 400) @(negedge clk);
    run_frame(3, 17, 1'b0, "R11 wrap");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    run_frame(0, 0, 1'b0, "R2 R4 R5 house0 key0");
    run_frame(15, 31, 1'b1, "R2 R10 house15 key31 local");
    run_frame(12, 12, 1'b0, "R2 R4 R5 all-zero bits");
    run_frame(9, 31, 1'b0, "R2 R4 all-one bits");
    run_frame(5, 20, 1'b0, "R2 R5 mixed");
    t_bad_start_gap();
    t_bad_start_phase();
    t_bad_data_gap();
    t_glitch();
    t_timeout_multi();
    t_timeout_single();
    t_wrap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule